// File: doc/BRIEF.md
# Dual-Channel DAC Serial Load Interface

This block is the digital front end of a two-channel 12-bit DAC. A host writes it over a three-wire serial port made of an active-low select, a serial clock and a data line. Each write is a 16-bit frame that carries a channel address, a power-down control bit, a reserved bit that must be zero, and the 12-bit code. A free-running system clock oversamples all three pins through synchronizers. The block finds serial-clock rising edges in the system clock domain and shifts the data in one bit per edge, most significant bit first.

The addressed holding register is loaded as soon as the sixteenth bit is captured. Select does not have to rise first. After that the frame counter stays at its limit until select goes high again, and that high period re-arms the port for the next frame. The two register values and the power-down flag feed the analog part, which is not modelled here. A one-cycle strobe reports each update and the channel it wrote. A one-cycle error pulse reports each frame that was rejected because its reserved bit was set.

Top module: `dac_serial_frontend`

## Requirements
- R1: Data is shifted in most significant bit first, one bit per serial-clock rising edge while select is low. Frame bit 15 is the channel (0 = A, 1 = B), bit 13 is power-down, bit 12 is reserved, and bits 11..0 are the code.
- R2: On the sixteenth rising edge of a select-low period, the code is written into the addressed register and the other register keeps its value. No select rising edge is needed.
- R3: While select is high, serial-clock edges change neither the shift state nor the bit count.
- R4: Rising edges after the sixteenth in the same select-low period shift nothing and cause no second update.
- R5: If select rises before sixteen bits have arrived, the frame is dropped with no update, and the next frame starts from a bit count of zero.
- R6: After reset both registers hold the midscale code 2048, power-down is 0, and no strobe or error pulse is active.
- R7: The power-down flag takes bit 13 of every accepted frame, whichever channel the frame addresses. Registers are still written while power-down is set.
- R8: A frame with bit 12 set changes no register and leaves power-down unchanged. It raises the error output for exactly one system clock cycle.
- R9: Each accepted frame raises the update strobe for exactly one system clock cycle. The channel output shows the written channel (0 = A, 1 = B).
- R10: Frame bit 14 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Serial port select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| code_a_o | output | 12 | Holding register of channel A |
| code_b_o | output | 12 | Holding register of channel B |
| pwrdn_o | output | 1 | Power-down flag for the analog part |
| upd_o | output | 1 | One-cycle strobe on each register update |
| upd_chan_o | output | 1 | Channel of the latest update (0 = A, 1 = B) |
| frame_err_o | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
The bench sweeps both channels with walking-one codes, the extreme codes and a spread of other codes, and toggles the ignored bit as it goes. A bit-order or field-position mistake would therefore put a wrong code in a register or in the wrong register. It sends extra clock edges after the sixteenth, pulses the clock while select is high, and raises select in mid-frame. A counter that does not freeze or re-arm correctly would show up as a second strobe, a corrupted code or a shifted next frame. Frames with the reserved bit set, and power-down frames aimed at either channel, test that a rejected frame leaves the flag and both registers alone and that the flag follows every accepted frame.

// File: rtl/dacsif_pkg.sv
package dacsif_pkg;
   typedef enum logic {
      CHAN_A = 1'b0,
      CHAN_B = 1'b1
   } dac_chan_e;

   localparam int unsigned NUM_CHAN  = 2;
   localparam int unsigned HDR_BITS  = 4;
endpackage

// File: rtl/dacsif_sync.sv
module dacsif_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacsif_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dacsif_frame_rx.sv
module dacsif_frame_rx #(
   parameter int unsigned DATA_W  = 12,
   parameter int unsigned FRAME_W = DATA_W + dacsif_pkg::HDR_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel_n,
   input  logic              s_sck,
   input  logic              s_sdi,
   output logic              frm_vld_o,
   output logic              frm_chan_o,
   output logic              frm_pwrdn_o,
   output logic              frm_rsvd_o,
   output logic [DATA_W-1:0] frm_code_o
);
   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

   if (FRAME_W != DATA_W + dacsif_pkg::HDR_BITS) begin : g_bad_frame
      $error("dacsif_frame_rx: FRAME_W must equal DATA_W plus header bits");
   end

   logic               sck_q;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] shreg;
   logic               done_q;
   logic               sck_rise;

   assign sck_rise = s_sck & ~sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         done_q  <= 1'b0;
      end else begin
         sck_q  <= s_sck;
         done_q <= 1'b0;
         if (s_sel_n) begin
            bit_cnt <= '0;
         end else if (sck_rise && (bit_cnt != CNT_FULL)) begin
            shreg   <= {shreg[FRAME_W-2:0], s_sdi};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_LAST) done_q <= 1'b1;
         end
      end
   end

   assign frm_vld_o   = done_q;
   assign frm_chan_o  = shreg[FRAME_W-1];
   assign frm_pwrdn_o = shreg[FRAME_W-3];
   assign frm_rsvd_o  = shreg[FRAME_W-4];
   assign frm_code_o  = shreg[DATA_W-1:0];

   // R5: a select-high sample re-arms the counter
   a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      s_sel_n |=> (bit_cnt == '0));

   // R4: once full, no more shifting in the same select-low period
   a_r4_freeze_full: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt == CNT_FULL && !s_sel_n) |=> (bit_cnt == CNT_FULL && $stable(shreg)));

   // R3: with select high the shift register holds
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel_n && bit_cnt == '0) |=> $stable(shreg));

   // R2: frame completion coincides with a full counter and lasts one cycle
   a_r2_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld_o |-> (bit_cnt == CNT_FULL));
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld_o |=> !frm_vld_o);
endmodule

// File: rtl/dacsif_reg_bank.sv
module dacsif_reg_bank #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_vld_i,
   input  logic              frm_chan_i,
   input  logic              frm_pwrdn_i,
   input  logic              frm_rsvd_i,
   input  logic [DATA_W-1:0] frm_code_i,
   output logic [DATA_W-1:0] code_a_o,
   output logic [DATA_W-1:0] code_b_o,
   output logic              pwrdn_o,
   output logic              upd_o,
   output logic              upd_chan_o,
   output logic              err_o
);
   import dacsif_pkg::*;

   localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

   logic accept;
   assign accept = frm_vld_i & ~frm_rsvd_i;

   for (genvar g = 0; g < int'(NUM_CHAN); g++) begin : g_ch
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               hold_q <= MIDSCALE;
         else if (accept && (frm_chan_i == 1'(g))) hold_q <= frm_code_i;
      end
   end

   assign code_a_o = g_ch[CHAN_A].hold_q;
   assign code_b_o = g_ch[CHAN_B].hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwrdn_o    <= 1'b0;
         upd_o      <= 1'b0;
         upd_chan_o <= CHAN_A;
         err_o      <= 1'b0;
      end else begin
         upd_o <= accept;
         err_o <= frm_vld_i & frm_rsvd_i;
         if (accept) begin
            pwrdn_o    <= frm_pwrdn_i;
            upd_chan_o <= frm_chan_i;
         end
      end
   end

   // R8: a rejected frame leaves every register untouched
   a_r8_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($stable(code_a_o) && $stable(code_b_o) && $stable(pwrdn_o)));
   a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   // R9: update strobe is a single cycle and never with an error
   a_r9_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);
   a_r9_upd_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_o && err_o));

   // R2: registers move only on an update, and only the addressed one
   a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> ($stable(code_a_o) && $stable(code_b_o) && $stable(pwrdn_o)));
   a_r2_other_a: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && upd_chan_o == CHAN_B) |-> $stable(code_a_o));
   a_r2_other_b: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && upd_chan_o == CHAN_A) |-> $stable(code_b_o));
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   output logic [DATA_W-1:0] code_a_o,
   output logic [DATA_W-1:0] code_b_o,
   output logic              pwrdn_o,
   output logic              upd_o,
   output logic              upd_chan_o,
   output logic              frame_err_o
);
   localparam int unsigned FRAME_W = DATA_W + dacsif_pkg::HDR_BITS;

   if (DATA_W < 2) begin : g_bad_width
      $error("dac_serial_frontend: DATA_W must be at least 2");
   end

   logic [2:0] pins_raw;
   logic [2:0] pins_s;
   logic       frm_vld, frm_chan, frm_pwrdn, frm_rsvd;
   logic [DATA_W-1:0] frm_code;

   assign pins_raw = {sel_n_i, sck_i, sdi_i};

   dacsif_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   dacsif_frame_rx #(
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_sel_n     (pins_s[2]),
      .s_sck       (pins_s[1]),
      .s_sdi       (pins_s[0]),
      .frm_vld_o   (frm_vld),
      .frm_chan_o  (frm_chan),
      .frm_pwrdn_o (frm_pwrdn),
      .frm_rsvd_o  (frm_rsvd),
      .frm_code_o  (frm_code)
   );

   dacsif_reg_bank #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_vld_i   (frm_vld),
      .frm_chan_i  (frm_chan),
      .frm_pwrdn_i (frm_pwrdn),
      .frm_rsvd_i  (frm_rsvd),
      .frm_code_i  (frm_code),
      .code_a_o    (code_a_o),
      .code_b_o    (code_b_o),
      .pwrdn_o     (pwrdn_o),
      .upd_o       (upd_o),
      .upd_chan_o  (upd_chan_o),
      .err_o       (frame_err_o)
   );
endmodule

// File: tb/tb_dac_serial_frontend.sv
module tb_dac_serial_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic [11:0] code_a, code_b;
   logic        pwrdn, upd, upd_chan, ferr;

   int checks = 0;
   int errors = 0;
   int upd_cnt = 0;
   int err_cnt = 0;
   int last_chan = 0;
   int cyc = 0;
   bit done = 1'b0;

   int exp_a = 2048, exp_b = 2048, exp_pd = 0, exp_upd = 0, exp_err = 0, exp_chan = 0;

   always #10 clk = ~clk;

   dac_serial_frontend dut (
      .clk (clk), .rst_n (rst_n), .sel_n_i (sel_n), .sck_i (sck), .sdi_i (sdi),
      .code_a_o (code_a), .code_b_o (code_b), .pwrdn_o (pwrdn), .upd_o (upd),
      .upd_chan_o (upd_chan), .frame_err_o (ferr)
   );

   // pulse counters: each high cycle is counted, so a pulse wider than one cycle is caught
   always @(negedge clk) begin
      if (rst_n) begin
         if (upd) begin upd_cnt++; last_chan = int'(upd_chan); end
         if (ferr) err_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic half_sck();
      repeat (4) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w, input int nbits, input int extra);
      sel_n = 1'b0;
      half_sck();
      for (int i = 0; i < nbits; i++) begin
         sdi = w[15-i];
         sck = 1'b0; half_sck();
         sck = 1'b1; half_sck();
      end
      for (int i = 0; i < extra; i++) begin
         sdi = ~sdi;
         sck = 1'b0; half_sck();
         sck = 1'b1; half_sck();
      end
      sck = 1'b0; half_sck();
      sel_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic model(input logic [15:0] w);
      if (w[12]) exp_err++;
      else begin
         if (w[15]) exp_b = int'(w[11:0]); else exp_a = int'(w[11:0]);
         exp_pd = int'(w[13]);
         exp_chan = int'(w[15]);
         exp_upd++;
      end
   endtask

   task automatic verify(input string tag);
      chk({tag, " code A"}, int'(code_a), exp_a);
      chk({tag, " code B"}, int'(code_b), exp_b);
      chk({tag, " power-down"}, int'(pwrdn), exp_pd);
      chk({tag, " update count"}, upd_cnt, exp_upd);
      chk({tag, " error count"}, err_cnt, exp_err);
      chk({tag, " update channel"}, last_chan, exp_chan);
   endtask

   function automatic logic [15:0] mk(input int ch, input int spare, input int pd,
                                      input int rsvd, input int code);
      return {1'(ch), 1'(spare), 1'(pd), 1'(rsvd), 12'(code)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      chk("R6 code A after reset", int'(code_a), 2048);
      chk("R6 code B after reset", int'(code_b), 2048);
      chk("R6 power-down after reset", int'(pwrdn), 0);
      chk("R6 strobe after reset", int'(upd), 0);
      chk("R6 error after reset", int'(ferr), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R2 R9 R10: sweep of codes on both channels, spare bit toggled
      for (int ch = 0; ch < 2; ch++) begin
         for (int k = 0; k < 20; k++) begin
            int code;
            logic [15:0] w;
            if (k < 12) code = 1 << k;
            else if (k == 12) code = 0;
            else if (k == 13) code = 4095;
            else code = (k * 1237 + ch * 77) % 4096;
            w = mk(ch, k % 2, 0, 0, code);
            send(w, 16, 0);
            model(w);
            verify("R1 R2 R9 R10 sweep");
         end
      end

      // R7: power-down from a channel B frame, then A frames while down, then clear
      begin
         logic [15:0] w;
         w = mk(1, 0, 1, 0, 12'h5A3); send(w, 16, 0); model(w); verify("R7 pd via B");
         w = mk(0, 1, 1, 0, 12'h3C7); send(w, 16, 0); model(w); verify("R7 write while pd");
         w = mk(0, 0, 0, 0, 12'h812); send(w, 16, 0); model(w); verify("R7 pd cleared");
         // R8: reserved bit set, with power-down and code that would differ
         w = mk(0, 0, 1, 1, 12'hFFF); send(w, 16, 0); model(w); verify("R8 reject A");
         w = mk(1, 1, 1, 1, 12'h001); send(w, 16, 0); model(w); verify("R8 reject B");
         // R4: extra edges after the sixteenth
         w = mk(0, 0, 0, 0, 12'hA5C); send(w, 16, 6); model(w); verify("R4 extra edges");
         w = mk(1, 0, 0, 0, 12'h0F1); send(w, 16, 0); model(w); verify("R4 next frame");
         // R5: abort before the sixteenth bit
         w = mk(0, 0, 1, 0, 12'h123); send(w, 10, 0); verify("R5 abort");
         w = mk(1, 0, 0, 0, 12'h456); send(w, 15, 0); verify("R5 abort at 15");
         w = mk(0, 1, 0, 0, 12'h789); send(w, 16, 0); model(w); verify("R5 frame after abort");
      end

      // R3: clock pulses with select high
      sdi = 1'b1;
      for (int i = 0; i < 7; i++) begin
         sck = 1'b1; half_sck();
         sck = 1'b0; half_sck();
      end
      repeat (6) @(negedge clk);
      verify("R3 idle clocks");
      begin
         logic [15:0] w;
         w = mk(1, 0, 0, 0, 12'h6B2); send(w, 16, 0); model(w); verify("R3 frame after idle clocks");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule